// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides whether an incoming CAN identifier may enter the foreground half of a double-buffered receive path. It holds eight code bytes and eight mask bytes. A two-bit grouping field arranges these bytes into two wide filters, four medium filters or eight narrow filters. The field can also shut the filter so that nothing is accepted.

When the receiver reports a finished frame, every filter compares the identifier against its code bytes. A mask bit of 1 makes its position a don't-care. If some filter matches and the foreground buffer is free, the block pulses a load strobe for one cycle. It also records the number of the lowest matching filter. That number always describes the message currently in the foreground buffer.

A small byte-wide register port gives access to the control byte and to the code and mask bytes. The grouping field can only be changed while a soft-reset input is high.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the control byte reads 0x00, so the grouping field is 00, and `fg_load` is low.
- R2: With grouping 11 (shut), no frame ever raises `fg_load`, and the hit index is not changed.
- R3: Mask rule and grouping 00: filter k (k = 0..1) is formed from code/mask bytes 4k..4k+3, and byte j of that group is compared with identifier byte j. Identifier byte 0 is `rx_id[31:24]`, byte 3 is `rx_id[7:0]`. A bit matches when it is equal to the code bit or its mask bit is 1. A filter hits when all its bits match.
- R4: With grouping 01, filter k (k = 0..3) uses bytes 2k and 2k+1 against identifier bytes 0 and 1.
- R5: With grouping 10, filter k (k = 0..7) uses byte k against identifier byte 0.
- R6: When several filters hit, the recorded index is that of the lowest-numbered hitting filter.
- R7: The hit index changes only in the cycle in which `fg_load` is high. Otherwise it keeps its previous value.
- R8: `fg_load` is high for exactly the one cycle after a clock edge at which `rx_done`, `fg_free` and at least one filter hit were all true.
- R9: The control byte at address 0x00 holds the grouping field in bits 5:4 and the hit index in bits 2:0. Bits 7, 6 and 3 read as zero.
- R10: A write to address 0x00 changes the grouping field only while `soft_rst` is high, and writes never change the hit index. Code byte b is at address 0x08+b and mask byte b is at address 0x10+b, each readable and writable at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft-reset level; enables grouping-field writes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| rx_id | input | 32 | Received identifier bytes, byte 0 in the top bits |
| rx_done | input | 1 | Frame complete in background buffer |
| fg_free | input | 1 | Foreground buffer may be overwritten |
| fg_load | output | 1 | Copy background to foreground this cycle |

## Verification
The load strobe and the new hit index come from one register stage. Both therefore appear one cycle after the edge that samples `rx_done`. The bench drives each frame on a falling edge, waits for the next rising edge, and checks `fg_load` and the control byte one nanosecond later. Register writes take effect at the edge that samples them, while reads are combinational. For this reason every configuration check is made only after the write's edge has passed, and the hit index is expected to stay put through every frame that the model says is not loaded.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
    typedef enum logic [1:0] {
        GRP_WIDE   = 2'b00,
        GRP_MEDIUM = 2'b01,
        GRP_NARROW = 2'b10,
        GRP_SHUT   = 2'b11
    } grp_mode_e;

    localparam int CTL_ADDR  = 0;
    localparam int CODE_BASE = 8;
    localparam int MASK_BASE = 16;
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
    import can_flt_pkg::*;
#(
    parameter int NB = 8,
    parameter int AW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [7:0]           wdata,
    output logic [NB-1:0][7:0]   code,
    output logic [NB-1:0][7:0]   mask,
    output grp_mode_e            mode
);
    typedef struct packed {
        logic [NB-1:0][7:0] code;
        logic [NB-1:0][7:0] mask;
        grp_mode_e          mode;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == AW'(CTL_ADDR) && soft_rst)
                st_d.mode = grp_mode_e'(wdata[5:4]);
            for (int b = 0; b < NB; b++) begin
                if (addr == AW'(CODE_BASE + b)) st_d.code[b] = wdata;
                if (addr == AW'(MASK_BASE + b)) st_d.mask[b] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = st_q.code;
    assign mask = st_q.mask;
    assign mode = st_q.mode;

    // R10: grouping field frozen while soft reset is low
    a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(CTL_ADDR) && !soft_rst) |=> $stable(mode));
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
    import can_flt_pkg::*;
#(
    parameter int NB   = 8,
    parameter int IDB  = 4,
    localparam int HITW = $clog2(NB)
) (
    input  grp_mode_e            mode,
    input  logic [NB-1:0][7:0]   code,
    input  logic [NB-1:0][7:0]   mask,
    input  logic [IDB*8-1:0]     id,
    output logic                 any_hit,
    output logic [HITW-1:0]      hit_idx
);
    logic [NB-1:0][IDB-1:0] byte_ok;
    logic [NB-1:0]          flt_hit;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        for (genvar j = 0; j < IDB; j++) begin : g_pos
            assign byte_ok[b][j] =
                ((code[b] ^ id[(IDB-1-j)*8 +: 8]) & ~mask[b]) == 8'h00;
        end
    end

    always_comb begin
        int fb;
        logic ok;
        case (mode)
            GRP_WIDE:   fb = IDB;
            GRP_MEDIUM: fb = IDB / 2;
            default:    fb = 1;
        endcase
        flt_hit = '0;
        for (int k = 0; k < NB; k++) begin
            ok = (mode != GRP_SHUT) && (k < NB / fb);
            for (int j = 0; j < IDB; j++) begin
                if (ok && j < fb)
                    ok = byte_ok[(k * fb + j) % NB][j];
            end
            flt_hit[k] = ok;
        end
    end

    always_comb begin
        any_hit = |flt_hit;
        hit_idx = '0;
        for (int k = NB - 1; k >= 0; k--) begin
            if (flt_hit[k]) hit_idx = HITW'(k);
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_flt_pkg::*;
#(
    parameter int NB  = 8,
    parameter int IDB = 4,
    parameter int AW  = 5,
    localparam int HITW = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [IDB*8-1:0] rx_id,
    input  logic             rx_done,
    input  logic             fg_free,
    output logic             fg_load
);
    typedef struct packed {
        logic            load;
        logic [HITW-1:0] hit;
    } core_t;

    logic [NB-1:0][7:0] code, mask;
    grp_mode_e          mode;
    logic               any_hit;
    logic [HITW-1:0]    hit_idx;
    core_t              st_d, st_q;

    can_flt_regs #(.NB(NB), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .code(code), .mask(mask), .mode(mode)
    );

    can_flt_match #(.NB(NB), .IDB(IDB)) u_match (
        .mode(mode), .code(code), .mask(mask), .id(rx_id),
        .any_hit(any_hit), .hit_idx(hit_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.load = rx_done && fg_free && any_hit;
        if (st_d.load) st_d.hit = hit_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fg_load = st_q.load;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(CTL_ADDR)) begin
            reg_rdata[5:4]      = mode;
            reg_rdata[HITW-1:0] = st_q.hit;
        end
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == AW'(CODE_BASE + b)) reg_rdata = code[b];
            if (reg_addr == AW'(MASK_BASE + b)) reg_rdata = mask[b];
        end
    end

    // R2: shut grouping never loads the foreground buffer
    a_r2_shut_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && mode == GRP_SHUT) |=> !fg_load);

    // R8: a load needs a finished frame and a free foreground buffer
    a_r8_load_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        fg_load |-> $past(rx_done && fg_free));

    // R7: hit index holds unless a load occurs
    a_r7_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fg_load |-> $stable(st_q.hit));

    // R8: load strobe lasts one cycle per frame pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fg_load && !$past(rx_done, 1)) |-> 1'b0);
endmodule

// File: tb/tb_can_accept_filter.sv
`timescale 1ns/1ps
module tb_can_accept_filter;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        soft_rst = 0;
    logic        reg_we = 0;
    logic [4:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic [31:0] rx_id = 0;
    logic        rx_done = 0;
    logic        fg_free = 0;
    logic        fg_load;

    can_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_id(rx_id), .rx_done(rx_done),
        .fg_free(fg_free), .fg_load(fg_load)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m_code [8];
    logic [7:0] m_mask [8];
    logic [1:0] m_mode = 0;
    logic [2:0] m_hit = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input logic [31:0] id);
        int fb, nf;
        logic ok;
        if (m_mode == 2'b11) return 4'h0;
        fb = (m_mode == 2'b00) ? 4 : (m_mode == 2'b01) ? 2 : 1;
        nf = 8 / fb;
        for (int k = 0; k < nf; k++) begin
            ok = 1;
            for (int j = 0; j < fb; j++) begin
                if (((m_code[k*fb+j] ^ id[31-8*j -: 8]) & ~m_mask[k*fb+j]) != 0) ok = 0;
            end
            if (ok) return {1'b1, 3'(k)};
        end
        return 4'h0;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_addr = 0;
        if (a >= 8 && a < 16) m_code[a-8] = d;
        if (a >= 16 && a < 24) m_mask[a-16] = d;
        if (a == 0 && soft_rst) m_mode = d[5:4];
    endtask

    task automatic set_mode(input logic [1:0] md);
        soft_rst = 1;
        wr(5'd0, {2'b00, md, 4'h0});
        soft_rst = 0;
    endtask

    task automatic frame(input string req, input logic [31:0] id, input logic free);
        logic [3:0] r;
        logic exp_load;
        @(negedge clk);
        rx_id = id; rx_done = 1; fg_free = free; reg_addr = 0;
        r = model(id);
        exp_load = r[3] && free;
        if (exp_load) m_hit = r[2:0];
        @(posedge clk);
        #1;
        check({req, " R8 load"}, 32'(fg_load), 32'(exp_load));
        check({req, " R7 R9 ctl"}, 32'(reg_rdata), {24'h0, 2'b00, m_mode, 1'b0, m_hit});
        @(negedge clk);
        rx_done = 0;
        @(posedge clk);
        #1;
        check({req, " R8 one-cycle"}, 32'(fg_load), 32'h0);
    endtask

    function automatic logic [31:0] near_id(input int fb);
        int k;
        logic [31:0] id;
        id = $urandom;
        k = $urandom_range(0, 8 / fb - 1);
        for (int j = 0; j < fb; j++) id[31-8*j -: 8] = m_code[k*fb+j];
        if ($urandom_range(0, 3) == 0) id[$urandom_range(0, 31)] ^= 1'b1;
        return id;
    endfunction

    task automatic rand_cfg();
        for (int b = 0; b < 8; b++) begin
            wr(5'(8 + b), 8'($urandom));
            wr(5'(16 + b), 8'($urandom & $urandom & $urandom));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int b = 0; b < 8; b++) begin m_code[b] = 0; m_mask[b] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check("R1 ctl reset", 32'(reg_rdata), 32'h0);
        check("R1 load reset", 32'(fg_load), 32'h0);

        // R10: locked write
        soft_rst = 0;
        wr(5'd0, 8'h20);
        #1; check("R10 locked", 32'(reg_rdata), 32'h0);
        // R10 R9: unlocked write of all ones
        soft_rst = 1;
        wr(5'd0, 8'hFF);
        soft_rst = 0;
        #1; check("R9 R10 unlocked", 32'(reg_rdata), 32'h30);
        wr(5'd9, 8'hA5);
        reg_addr = 5'd9; #1; check("R10 code read", 32'(reg_rdata), 32'hA5);
        wr(5'd19, 8'h3C);
        reg_addr = 5'd19; #1; check("R10 mask read", 32'(reg_rdata), 32'h3C);
        reg_addr = 0;

        // R6 priority in narrow grouping
        set_mode(2'b10);
        for (int b = 0; b < 8; b++) begin wr(5'(8 + b), 8'h55); wr(5'(16 + b), 8'h00); end
        frame("R6 R5 all hit", 32'h55000000, 1);
        check("R6 idx0", 32'(m_hit), 32'h0);
        wr(5'd8, 8'hAA);
        frame("R6 skip0", 32'h55FFFFFF, 1);
        check("R6 idx1", 32'(m_hit), 32'h1);
        wr(5'd9, 8'hAA);
        frame("R6 skip1", 32'h55000000, 1);
        // R8: foreground busy
        wr(5'd15, 8'h11);
        frame("R8 busy", 32'h11000000, 0);
        // R7: no match keeps hit
        frame("R7 miss", 32'h99000000, 1);
        // R3 mask don't-care
        set_mode(2'b00);
        wr(5'd16, 8'hFF);
        frame("R3 masked", 32'h00555555, 1);
        // R2 shut
        set_mode(2'b11);
        for (int b = 0; b < 8; b++) wr(5'(16 + b), 8'hFF);
        frame("R2 shut", 32'h12345678, 1);

        for (int md = 0; md < 4; md++) begin
            set_mode(2'(md));
            for (int n = 0; n < 6; n++) begin
                rand_cfg();
                for (int f = 0; f < 20; f++) begin
                    case (md)
                        0: frame("R3 rand", near_id(4), $urandom_range(0, 4) != 0);
                        1: frame("R4 rand", near_id(2), $urandom_range(0, 4) != 0);
                        2: frame("R5 rand", near_id(1), $urandom_range(0, 4) != 0);
                        default: frame("R2 rand", near_id(1), 1);
                    endcase
                end
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule